// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Accessor

This block moves single bytes between a local client and ring buffers that live in the memory of another processor. It reaches that memory only through a bus master interface. It requests the bus, waits for the grant, performs byte reads and writes with a ready handshake, then drops the request and waits for the grant to fall. Each ring keeps three control bytes directly below its base address: the size mask at base-3, the producer (input) index at base-2 and the consumer (output) index at base-1. Data byte k sits at base+k.

For each of a parameterised number of channels the block caches a descriptor holding the base address, the mask and both indices. The client issues one operation at a time with a channel select. The operations are init, empty test, full test, get and put. Every operation that touches memory holds the bus for its own tenure or tenures. Get and put block by polling: each poll is a separate tenure, so the remote side can update its index between polls.

Top module: `shm_ring_access`

## Requirements
- R1: After reset op_ready_o is 1, while done_o, bus_req_o and mem_valid_o are 0.
- R2: Init (op code 0) stores op_addr_i as the channel base. In one bus tenure it reads base-3, base-2 and base-1 into the cached mask, input index and output index, and finishes with flag_o=0. Init with a zero address finishes with flag_o=0 and no tenure, and leaves the channel unconfigured.
- R3: Empty (op code 1) uses one tenure to read base-2, and returns flag_o=1 exactly when that byte equals the cached output index.
- R4: Full (op code 2) uses one tenure to read base-1, and returns flag_o=1 exactly when (cached input index + 1) AND mask equals that byte.
- R5: Get (op code 3) reads the byte at base + cached output index and returns it on rdata_o together with done_o and flag_o=0. It advances the output index by one modulo mask+1 and writes the new value to base-1.
- R6: Put (op code 4) writes op_wdata_i to base + cached input index and finishes with flag_o=0. It advances the input index by one modulo mask+1 and writes the new value to base-2.
- R7: A get or put that is not blocked takes exactly two tenures: one for the check and one for the transfer. While blocked, it repeats the check, each time in a fresh tenure, until the remote index changes.
- R8: A channel whose base is zero, or whose select is at or above the channel count, reports empty and full as flag_o=1. On such a channel, get and put finish at once with flag_o=1. Op codes 5 to 7 also finish at once with flag_o=1. None of these cases raises bus_req_o.
- R9: mem_valid_o is high only while both bus_req_o and bus_gnt_i are high. bus_req_o is low whenever done_o is high.
- R10: While mem_valid_o is high and mem_ready_i is low, the address, write flag and write data stay stable and mem_valid_o remains high.
- R11: done_o is a one-cycle pulse. op_ready_o is low from acceptance until after done_o.
- R12: Each channel keeps its own descriptor, so operations on one channel do not change the results on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation request, taken when op_ready_o is high |
| op_code_i | input | 3 | 0 init, 1 empty, 2 full, 3 get, 4 put |
| op_chan_i | input | CW | Channel select |
| op_addr_i | input | AW | Ring base address (init only) |
| op_wdata_i | input | 8 | Byte to put |
| op_ready_o | output | 1 | Idle, able to take an operation |
| done_o | output | 1 | One-cycle completion pulse |
| flag_o | output | 1 | Empty/full result, or 1 when refused |
| rdata_o | output | 8 | Byte returned by get |
| bus_req_o | output | 1 | Bus request to the remote side |
| bus_gnt_i | input | 1 | Bus grant |
| mem_valid_o | output | 1 | Byte access pending |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | 8 | Write byte |
| mem_ready_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 8 | Read byte, valid with mem_ready_i |

## Verification
The bench drives both indices around the wrap point of a four-byte ring. If the design added one without masking, it would write index 4 back and address past the ring. It places two configured channels next to two unconfigured ones, including one initialised with a zero base. If the design left out the zero-base check, it would request the bus and fetch control bytes from below address zero. The bench stalls a get on an empty ring and a put on a full ring until the bench itself, acting as the remote side, updates the far index. If a design cached the remote index, or held one tenure across the wait, it would either never finish or show too few bus requests. The memory model varies its wait states between accesses, so a design that moved its address before ready would read or write the wrong byte.

// File: rtl/shm_ring_pkg.sv
package shm_ring_pkg;
  localparam int unsigned IDX_W = 8;
  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [2:0] {
    OP_INIT  = 3'd0,
    OP_EMPTY = 3'd1,
    OP_FULL  = 3'd2,
    OP_GET   = 3'd3,
    OP_PUT   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    BC_ACQ = 2'd0,
    BC_RD  = 2'd1,
    BC_WR  = 2'd2,
    BC_REL = 2'd3
  } bcmd_e;
endpackage

// File: rtl/shm_ring_desc.sv
module shm_ring_desc
  import shm_ring_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int CW     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] sel_i,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          mask_we_i,
  input  logic          in_we_i,
  input  logic          out_we_i,
  input  idx_t          idx_i,
  output logic [AW-1:0] base_o,
  output idx_t          mask_o,
  output idx_t          in_o,
  output idx_t          out_o
);
  logic [AW-1:0] base_q [NUM_CH];
  idx_t          mask_q [NUM_CH];
  idx_t          in_q   [NUM_CH];
  idx_t          out_q  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (int'(sel_i) == g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g] <= '0;
        mask_q[g] <= '0;
        in_q[g]   <= '0;
        out_q[g]  <= '0;
      end else if (hit) begin
        if (base_we_i) base_q[g] <= base_i;
        if (mask_we_i) mask_q[g] <= idx_i;
        if (in_we_i)   in_q[g]   <= idx_i;
        if (out_we_i)  out_q[g]  <= idx_i;
      end
    end
  end

  // out-of-range select reads as an unconfigured channel
  always_comb begin
    base_o = '0;
    mask_o = '0;
    in_o   = '0;
    out_o  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(sel_i) == i) begin
        base_o = base_q[i];
        mask_o = mask_q[i];
        in_o   = in_q[i];
        out_o  = out_q[i];
      end
    end
  end
endmodule

// File: rtl/shm_ring_bus.sv
module shm_ring_bus
  import shm_ring_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  bcmd_e         cmd_i,
  input  logic [AW-1:0] addr_i,
  input  idx_t          wdata_i,
  output logic          cmd_done_o,
  output idx_t          rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output idx_t          mem_wdata_o,
  input  logic          mem_ready_i,
  input  idx_t          mem_rdata_i
);
  typedef enum logic [1:0] {BP_IDLE, BP_ACQ, BP_ACC, BP_REL} bp_e;
  bp_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= BP_IDLE;
      bus_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      case (st_q)
        BP_IDLE: if (cmd_valid_i) begin
          case (cmd_i)
            BC_ACQ: begin bus_req_o <= 1'b1; st_q <= BP_ACQ; end
            BC_RD: begin
              mem_we_o   <= 1'b0;
              mem_addr_o <= addr_i;
              st_q       <= BP_ACC;
            end
            BC_WR: begin
              mem_we_o    <= 1'b1;
              mem_addr_o  <= addr_i;
              mem_wdata_o <= wdata_i;
              st_q        <= BP_ACC;
            end
            default: begin bus_req_o <= 1'b0; st_q <= BP_REL; end
          endcase
        end
        BP_ACQ: if (bus_gnt_i) st_q <= BP_IDLE;
        BP_ACC: if (mem_ready_i) st_q <= BP_IDLE;
        default: if (!bus_gnt_i) st_q <= BP_IDLE;
      endcase
    end
  end

  assign mem_valid_o = (st_q == BP_ACC);
  assign rdata_o     = mem_rdata_i;
  assign cmd_done_o  = ((st_q == BP_ACQ) && bus_gnt_i)
                    || ((st_q == BP_ACC) && mem_ready_i)
                    || ((st_q == BP_REL) && !bus_gnt_i);
endmodule

// File: rtl/shm_ring_ctrl.sv
module shm_ring_ctrl
  import shm_ring_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int CW     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [2:0]    op_code_i,
  input  logic [CW-1:0] op_chan_i,
  input  logic [AW-1:0] op_addr_i,
  input  idx_t          op_wdata_i,
  output logic          op_ready_o,
  output logic          done_o,
  output logic          flag_o,
  output idx_t          rdata_o,
  output logic [CW-1:0] d_sel_o,
  output logic          d_base_we_o,
  output logic [AW-1:0] d_base_o,
  output logic          d_mask_we_o,
  output logic          d_in_we_o,
  output logic          d_out_we_o,
  output idx_t          d_idx_o,
  input  logic [AW-1:0] d_base_i,
  input  idx_t          d_mask_i,
  input  idx_t          d_in_i,
  input  idx_t          d_out_i,
  output logic          cmd_valid_o,
  output bcmd_e         cmd_o,
  output logic [AW-1:0] cmd_addr_o,
  output idx_t          cmd_wdata_o,
  input  logic          cmd_done_i,
  input  idx_t          cmd_rdata_i
);
  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_ACC, S_REL, S_DONE} st_e;
  st_e st_q;

  logic [2:0]    op_q;
  logic [CW-1:0] chan_q;
  idx_t          wdata_q;
  logic          xfer_q;
  logic [1:0]    step_q;
  logic          hit_q;
  logic          flag_q;
  idx_t          rdata_q;

  logic [AW-1:0] base_m1, base_m2, base_m3;
  idx_t          next_in, next_out;
  bcmd_e         acc_cmd;
  logic [AW-1:0] acc_addr;
  idx_t          acc_wdata;
  logic          acc_last;
  logic          hit_now;
  logic          chan_ok;
  logic          acc_fire;

  assign base_m1  = d_base_i - AW'(1);
  assign base_m2  = d_base_i - AW'(2);
  assign base_m3  = d_base_i - AW'(3);
  assign next_in  = (d_in_i + 8'd1) & d_mask_i;
  assign next_out = (d_out_i + 8'd1) & d_mask_i;
  assign chan_ok  = (int'(op_chan_i) < NUM_CH);
  assign acc_fire = (st_q == S_ACC) && cmd_done_i;

  always_comb begin
    acc_cmd   = BC_RD;
    acc_addr  = base_m2;
    acc_wdata = '0;
    acc_last  = 1'b1;
    case (op_q)
      OP_INIT: begin
        acc_addr = base_m3 + AW'(step_q);
        acc_last = (step_q == 2'd2);
      end
      OP_EMPTY: acc_addr = base_m2;
      OP_FULL:  acc_addr = base_m1;
      OP_GET: begin
        if (!xfer_q) acc_addr = base_m2;
        else if (step_q == 2'd0) begin
          acc_addr = d_base_i + AW'(d_out_i);
          acc_last = 1'b0;
        end else begin
          acc_cmd   = BC_WR;
          acc_addr  = base_m1;
          acc_wdata = d_out_i;
        end
      end
      OP_PUT: begin
        if (!xfer_q) acc_addr = base_m1;
        else if (step_q == 2'd0) begin
          acc_cmd   = BC_WR;
          acc_addr  = d_base_i + AW'(d_in_i);
          acc_wdata = wdata_q;
          acc_last  = 1'b0;
        end else begin
          acc_cmd   = BC_WR;
          acc_addr  = base_m2;
          acc_wdata = d_in_i;
        end
      end
      default: ;
    endcase
  end

  // empty-style check compares remote input index; full-style the remote output index
  assign hit_now = ((op_q == OP_EMPTY) || (op_q == OP_GET))
                 ? (cmd_rdata_i == d_out_i)
                 : (next_in == cmd_rdata_i);

  assign cmd_valid_o = (st_q == S_ACQ) || (st_q == S_ACC) || (st_q == S_REL);
  assign cmd_o       = (st_q == S_ACQ) ? BC_ACQ : (st_q == S_REL) ? BC_REL : acc_cmd;
  assign cmd_addr_o  = acc_addr;
  assign cmd_wdata_o = acc_wdata;

  assign d_sel_o     = (st_q == S_IDLE) ? op_chan_i : chan_q;
  assign d_base_we_o = (st_q == S_IDLE) && op_valid_i && (op_code_i == OP_INIT) && chan_ok;
  assign d_base_o    = op_addr_i;
  assign d_mask_we_o = acc_fire && (op_q == OP_INIT) && (step_q == 2'd0);
  assign d_in_we_o   = acc_fire && (((op_q == OP_INIT) && (step_q == 2'd1))
                    || ((op_q == OP_PUT) && xfer_q && (step_q == 2'd0)));
  assign d_out_we_o  = acc_fire && (((op_q == OP_INIT) && (step_q == 2'd2))
                    || ((op_q == OP_GET) && xfer_q && (step_q == 2'd0)));
  assign d_idx_o     = (op_q == OP_INIT) ? cmd_rdata_i
                     : (op_q == OP_PUT) ? next_in : next_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= '0;
      chan_q  <= '0;
      wdata_q <= '0;
      xfer_q  <= 1'b0;
      step_q  <= '0;
      hit_q   <= 1'b0;
      flag_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (op_valid_i) begin
          op_q    <= op_code_i;
          chan_q  <= op_chan_i;
          wdata_q <= op_wdata_i;
          xfer_q  <= 1'b0;
          step_q  <= '0;
          if (op_code_i == OP_INIT) begin
            flag_q <= 1'b0;
            st_q   <= (chan_ok && (op_addr_i != '0)) ? S_ACQ : S_DONE;
          end else if ((op_code_i > OP_PUT) || (d_base_i == '0)) begin
            flag_q <= 1'b1;
            st_q   <= S_DONE;
          end else begin
            st_q <= S_ACQ;
          end
        end
        S_ACQ: if (cmd_done_i) st_q <= S_ACC;
        S_ACC: if (cmd_done_i) begin
          if (!xfer_q && (op_q != OP_INIT)) hit_q <= hit_now;
          if ((op_q == OP_GET) && xfer_q && (step_q == 2'd0)) rdata_q <= cmd_rdata_i;
          if (acc_last) st_q <= S_REL;
          else step_q <= step_q + 2'd1;
        end
        S_REL: if (cmd_done_i) begin
          step_q <= '0;
          case (op_q)
            OP_EMPTY, OP_FULL: begin flag_q <= hit_q; st_q <= S_DONE; end
            OP_GET, OP_PUT: begin
              if (xfer_q) begin
                flag_q <= 1'b0;
                st_q   <= S_DONE;
              end else begin
                // blocked: poll again under a new grant
                if (!hit_q) xfer_q <= 1'b1;
                st_q <= S_ACQ;
              end
            end
            default: begin flag_q <= 1'b0; st_q <= S_DONE; end
          endcase
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign op_ready_o = (st_q == S_IDLE);
  assign done_o     = (st_q == S_DONE);
  assign flag_o     = flag_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/shm_ring_access.sv
module shm_ring_access
  import shm_ring_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [2:0]    op_code_i,
  input  logic [CW-1:0] op_chan_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [7:0]    op_wdata_i,
  output logic          op_ready_o,
  output logic          done_o,
  output logic          flag_o,
  output logic [7:0]    rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [7:0]    mem_rdata_i
);
  logic [CW-1:0] d_sel;
  logic          d_base_we, d_mask_we, d_in_we, d_out_we;
  logic [AW-1:0] d_base_w, d_base_r;
  idx_t          d_idx, d_mask, d_in, d_out;
  logic          cmd_valid, cmd_done;
  bcmd_e         cmd;
  logic [AW-1:0] cmd_addr;
  idx_t          cmd_wdata, cmd_rdata;

  shm_ring_desc #(.NUM_CH(NUM_CH), .AW(AW), .CW(CW)) u_desc (
    .clk_i, .rst_ni,
    .sel_i(d_sel), .base_we_i(d_base_we), .base_i(d_base_w),
    .mask_we_i(d_mask_we), .in_we_i(d_in_we), .out_we_i(d_out_we), .idx_i(d_idx),
    .base_o(d_base_r), .mask_o(d_mask), .in_o(d_in), .out_o(d_out)
  );

  shm_ring_ctrl #(.NUM_CH(NUM_CH), .AW(AW), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni,
    .op_valid_i, .op_code_i, .op_chan_i, .op_addr_i, .op_wdata_i,
    .op_ready_o, .done_o, .flag_o, .rdata_o,
    .d_sel_o(d_sel), .d_base_we_o(d_base_we), .d_base_o(d_base_w),
    .d_mask_we_o(d_mask_we), .d_in_we_o(d_in_we), .d_out_we_o(d_out_we), .d_idx_o(d_idx),
    .d_base_i(d_base_r), .d_mask_i(d_mask), .d_in_i(d_in), .d_out_i(d_out),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_addr_o(cmd_addr), .cmd_wdata_o(cmd_wdata),
    .cmd_done_i(cmd_done), .cmd_rdata_i(cmd_rdata)
  );

  shm_ring_bus #(.AW(AW)) u_bus (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .addr_i(cmd_addr), .wdata_i(cmd_wdata),
    .cmd_done_o(cmd_done), .rdata_o(cmd_rdata),
    .bus_req_o, .bus_gnt_i,
    .mem_valid_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ready_i, .mem_rdata_i
  );
endmodule

// File: rtl/shm_ring_access_chk.sv
module shm_ring_access_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_ready_o,
  input logic          done_o,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic          mem_valid_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [7:0]    mem_wdata_o,
  input logic          mem_ready_i
);
  // R9
  access_in_tenure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (bus_req_o && bus_gnt_i));

  // R9
  released_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);

  // R10
  access_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  busy_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !op_ready_o);
endmodule

bind shm_ring_access shm_ring_access_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_ready_o(op_ready_o), .done_o(done_o),
  .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .mem_valid_o(mem_valid_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .mem_ready_i(mem_ready_i)
);

// File: tb/shm_ring_access_test.sv
module shm_ring_access_test;
  localparam int AW = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [1:0] op_chan = '0;
  logic [AW-1:0] op_addr = '0;
  logic [7:0] op_wdata = '0;
  logic       op_ready, done, flag;
  logic [7:0] rdata;
  logic       bus_req, bus_gnt;
  logic       mem_valid, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int errors = 0;
  int checks = 0;
  int req_cnt = 0;
  logic req_d = 1'b0;

  always #4 clk = ~clk;

  shm_ring_access #(.NUM_CH(4), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .op_valid_i(op_valid), .op_code_i(op_code), .op_chan_i(op_chan),
    .op_addr_i(op_addr), .op_wdata_i(op_wdata),
    .op_ready_o(op_ready), .done_o(done), .flag_o(flag), .rdata_o(rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  // remote memory and arbiter model
  logic [7:0] mem [512];
  logic [1:0] wcnt = '0;
  logic [1:0] lat  = '0;
  logic       hw_en = 1'b0;
  logic [8:0] hw_addr = '0;
  logic [7:0] hw_data = '0;
  logic       gnt_q = 1'b0;

  assign bus_gnt   = gnt_q;
  assign mem_ready = mem_valid && (wcnt == lat);
  assign mem_rdata = mem[mem_addr[8:0]];

  always @(posedge clk) begin
    gnt_q <= bus_req;
    req_d <= bus_req;
    if (bus_req && !req_d) req_cnt <= req_cnt + 1;
    if (hw_en) mem[hw_addr] <= hw_data;
    if (mem_valid) begin
      if (mem_ready) begin
        wcnt <= '0;
        lat  <= (lat == 2'd2) ? 2'd0 : lat + 2'd1;
        if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
      end else begin
        wcnt <= wcnt + 2'd1;
      end
    end
  end

  task automatic host_write(input int a, input int d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = 9'(a); hw_data = 8'(d);
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic op_busy = 1'b0;

  task automatic do_op(input int code, input int ch, input int arg,
                       output int f, output int d, output int nreq);
    int r0;
    @(negedge clk);
    r0 = req_cnt;
    op_busy  = 1'b1;
    op_valid = 1'b1; op_code = 3'(code); op_chan = 2'(ch);
    op_addr  = AW'(arg); op_wdata = 8'(arg);
    @(negedge clk);
    op_valid = 1'b0;
    while (!done) @(negedge clk);
    f = int'(flag); d = int'(rdata);
    nreq = req_cnt - r0;
    op_busy = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ch;
    logic [15:0] arg;
    logic        ef;
    logic [7:0]  ed;
    logic [3:0]  er;
  } vec_t;

  localparam int TBL_N = 25;
  localparam vec_t TBL [TBL_N] = '{
    '{3'd0, 2'd0, 16'h0040, 1'b0, 8'h00, 4'd1},  // R2 init ch0
    '{3'd1, 2'd0, 16'h0000, 1'b1, 8'h00, 4'd1},  // R3
    '{3'd2, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd1},  // R4
    '{3'd4, 2'd0, 16'h00A5, 1'b0, 8'h00, 4'd2},  // R6 R7
    '{3'd1, 2'd0, 16'h0000, 1'b0, 8'h00, 4'd1},  // R3
    '{3'd3, 2'd0, 16'h0000, 1'b0, 8'hA5, 4'd2},  // R5 R7
    '{3'd1, 2'd0, 16'h0000, 1'b1, 8'h00, 4'd1},  // R3
    '{3'd0, 2'd1, 16'h0100, 1'b0, 8'h00, 4'd1},  // R2 init ch1
    '{3'd4, 2'd1, 16'h0011, 1'b0, 8'h00, 4'd2},  // R6
    '{3'd4, 2'd1, 16'h0022, 1'b0, 8'h00, 4'd2},  // R6
    '{3'd2, 2'd1, 16'h0000, 1'b0, 8'h00, 4'd1},  // R4
    '{3'd4, 2'd1, 16'h0033, 1'b0, 8'h00, 4'd2},  // R6 wrap
    '{3'd2, 2'd1, 16'h0000, 1'b1, 8'h00, 4'd1},  // R4 full
    '{3'd3, 2'd1, 16'h0000, 1'b0, 8'h11, 4'd2},  // R5
    '{3'd2, 2'd1, 16'h0000, 1'b0, 8'h00, 4'd1},  // R4
    '{3'd3, 2'd1, 16'h0000, 1'b0, 8'h22, 4'd2},  // R5
    '{3'd3, 2'd1, 16'h0000, 1'b0, 8'h33, 4'd2},  // R5 wrap
    '{3'd1, 2'd1, 16'h0000, 1'b1, 8'h00, 4'd1},  // R3
    '{3'd1, 2'd2, 16'h0000, 1'b1, 8'h00, 4'd0},  // R8
    '{3'd2, 2'd2, 16'h0000, 1'b1, 8'h00, 4'd0},  // R8
    '{3'd3, 2'd2, 16'h0000, 1'b1, 8'h00, 4'd0},  // R8
    '{3'd4, 2'd3, 16'h0000, 1'b1, 8'h00, 4'd0},  // R8
    '{3'd0, 2'd3, 16'h0000, 1'b0, 8'h00, 4'd0},  // R2 zero base
    '{3'd1, 2'd3, 16'h0000, 1'b1, 8'h00, 4'd0},  // R8
    '{3'd1, 2'd0, 16'h0000, 1'b1, 8'h00, 4'd1}   // R12 ch0 untouched
  };

  initial begin : watchdog
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int f, d, n, r0;
    // ring 0: base 0x040, mask 7, indices 0
    hw_en = 1'b1; hw_addr = 9'h03D; hw_data = 8'd7; @(negedge clk);
    hw_addr = 9'h03E; hw_data = 8'd0; @(negedge clk);
    hw_addr = 9'h03F; hw_data = 8'd0; @(negedge clk);
    // ring 1: base 0x100, mask 3, indices 1
    hw_addr = 9'h0FD; hw_data = 8'd3; @(negedge clk);
    hw_addr = 9'h0FE; hw_data = 8'd1; @(negedge clk);
    hw_addr = 9'h0FF; hw_data = 8'd1; @(negedge clk);
    hw_en = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 ready", int'(op_ready), 1);
    chk("R1 done", int'(done), 0);
    chk("R1 req", int'(bus_req), 0);
    chk("R1 valid", int'(mem_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", int'(op_ready), 1);

    for (int i = 0; i < TBL_N; i++) begin
      do_op(int'(TBL[i].op), int'(TBL[i].ch), int'(TBL[i].arg), f, d, n);
      chk($sformatf("R3/R4/R8 flag vec%0d", i), f, int'(TBL[i].ef));
      chk($sformatf("R7 tenures vec%0d", i), n, int'(TBL[i].er));
      if (TBL[i].op == 3'd3 && TBL[i].ef == 1'b0)
        chk($sformatf("R5 data vec%0d", i), d, int'(TBL[i].ed));
    end

    // R6 R5 remote contents
    chk("R6 byte ch0", int'(mem[9'h040]), 8'hA5);
    chk("R6 in idx ch0", int'(mem[9'h03E]), 1);
    chk("R5 out idx ch0", int'(mem[9'h03F]), 1);
    chk("R6 byte ch1 idx3", int'(mem[9'h103]), 8'h33);
    chk("R6 in idx wrap ch1", int'(mem[9'h0FE]), 0);
    chk("R5 out idx wrap ch1", int'(mem[9'h0FF]), 0);
    chk("R12 ch1 mask kept", int'(mem[9'h0FD]), 3);

    // R7 blocked get polls until the remote producer advances
    r0 = req_cnt;
    fork
      do_op(3, 0, 0, f, d, n);
      begin
        repeat (150) @(negedge clk);
        chk("R7 get still blocked", int'(op_busy && !done), 1);
        chk("R7 get polls", int'((req_cnt - r0) >= 3), 1);
        host_write(9'h041, 8'h5A);
        host_write(9'h03E, 2);
      end
    join
    chk("R5 blocked get data", d, 8'h5A);
    chk("R5 blocked get flag", f, 0);
    chk("R5 out idx after wait", int'(mem[9'h03F]), 2);

    // R7 blocked put: fill ch1 (in 0, out 0) with three bytes
    do_op(4, 1, 8'h44, f, d, n);
    do_op(4, 1, 8'h55, f, d, n);
    do_op(4, 1, 8'h66, f, d, n);
    do_op(2, 1, 0, f, d, n);
    chk("R4 ch1 full again", f, 1);
    r0 = req_cnt;
    fork
      do_op(4, 1, 8'h77, f, d, n);
      begin
        repeat (150) @(negedge clk);
        chk("R7 put still blocked", int'(op_busy && !done), 1);
        chk("R7 put polls", int'((req_cnt - r0) >= 3), 1);
        chk("R7 slot untouched while full", int'(mem[9'h103]), 8'h33);
        host_write(9'h0FF, 1);
      end
    join
    chk("R6 blocked put flag", f, 0);
    chk("R6 blocked put byte", int'(mem[9'h103]), 8'h77);
    chk("R6 in idx wrap after wait", int'(mem[9'h0FE]), 0);

    // R8 unused op code
    do_op(7, 0, 0, f, d, n);
    chk("R8 bad code flag", f, 1);
    chk("R8 bad code no tenure", n, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule